// File: doc/BRIEF.md
# Power-Up Inactivity Sleep Guard

This block decides the operating mode of a peripheral that puts itself to sleep when software leaves it untouched after power-up. After a power-on reset the peripheral sits in standby with its power-on flag raised, and a long inactivity countdown begins. If software neither moves the peripheral into normal mode nor clears the power-on flag before the countdown runs out, the block drops it into sleep. While asleep the serial host interface is treated as unresponsive: configuration writes and flag clears are discarded.

Software can stop the automatic sleep entry by setting a failsafe-disable bit through a configuration write. That bit does not survive a power-up or a reset request, so boot code has to write it again each time. A wake button, a bus wake pattern or a reset request brings the peripheral back from sleep to standby, and the countdown starts again from zero. The countdown length is given as a tick prescale and a tick count, so a simulation can use a short window while the default covers four minutes at a 40 MHz clock.

Top module: `powerup_sleep_failsafe`

## Requirements
- R1: While `rst_n` is low and directly after it is released, `mode_o` is standby (0), `por_flag_o` is 1, `fs_dis_o` is 0 and `spi_mute_o` is 0. A power-on reset in the middle of operation clears a previously set disable bit.
- R2: If no software action and no reset request occur, `mode_o` changes to sleep (2) on exactly the PRESCALE*TIMEOUT_TICKS-th rising edge after reset release, and is still standby one edge earlier.
- R3: A configuration write (`cfg_wr`) whose mode field `cfg_mode` is 2'b10 moves the block to normal (1) on that edge and cancels the countdown, so it stays in normal indefinitely. A field of 2'b01 returns it to standby without re-arming the countdown.
- R4: A `flag_clr` pulse while awake clears `por_flag_o` on that edge and cancels the countdown, so the block then stays in standby indefinitely.
- R5: While `fs_dis_o` is 1 the countdown is frozen and no sleep entry happens. When a later write sets it back to 0, the countdown resumes from the frozen point and sleep follows after the remaining ticks only.
- R6: `spi_mute_o` is 1 exactly while `mode_o` is sleep. While asleep, configuration writes and flag clears leave the mode, `por_flag_o` and `fs_dis_o` unchanged.
- R7: In sleep, a `wake_btn` or `wake_bus` pulse returns the block to standby on that edge and re-arms a full countdown. In standby or normal, these wake inputs have no effect.
- R8: An `ext_rst` pulse, in any mode, forces standby, sets `por_flag_o`, clears `fs_dis_o` and restarts a full countdown. It overrides any other input in the same cycle.
- R9: A software action that cancels the countdown in the same cycle as its expiry wins: the block enters the requested mode, not sleep.
- R10: Every configuration write while awake loads `cfg_fs_dis` into `fs_dis_o`. A mode field of 2'b00 or 2'b11 keeps the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| ext_rst | input | 1 | Synchronous reset request pulse (reset button) |
| wake_btn | input | 1 | Wake pushbutton pulse |
| wake_bus | input | 1 | Bus wake-pattern detected pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode field of the write: 01 standby, 10 normal, 00/11 keep |
| cfg_fs_dis | input | 1 | Failsafe-disable bit of the write |
| flag_clr | input | 1 | Power-on flag clear strobe |
| mode_o | output | 2 | Current mode: 0 standby, 1 normal, 2 sleep |
| spi_mute_o | output | 1 | Host serial interface unresponsive (asleep) |
| por_flag_o | output | 1 | Power-on flag |
| fs_dis_o | output | 1 | Failsafe-disable bit currently in force |

## Verification
Every strobe acts on the rising edge that samples it, so mode, flag and disable bit are due one edge after the strobe. The bench therefore drives each stimulus for one edge and reads the outputs at the next falling edge. Sleep entry is due only after PRESCALE*TIMEOUT_TICKS edges of unfrozen counting. The bench counts every edge spent on stimulus and waiting since arming, and checks both the edge before expiry and the expiry edge itself. For the frozen case it adds only the edges on which the disable bit was clear.

// File: rtl/psf_pkg.sv
package psf_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_NORMAL  = 2'd1,
        MODE_SLEEP   = 2'd2
    } mode_e;

    localparam logic [1:0] REQ_KEEP    = 2'b00;
    localparam logic [1:0] REQ_STANDBY = 2'b01;
    localparam logic [1:0] REQ_NORMAL  = 2'b10;

    typedef struct packed {
        mode_e mode;
        logic  armed;
        logic  por_flag;
        logic  fs_dis;
    } ctl_state_t;

endpackage

// File: rtl/psf_tick_gen.sv
module psf_tick_gen #(
    parameter int PRESCALE = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [W-1:0] LAST = W'(PRESCALE - 1);

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = en && !clr;
        end else begin : g_div
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                tick  = en && !clr && (cnt_q == LAST);
                if (clr) begin
                    cnt_d = '0;
                end else if (en) begin
                    cnt_d = tick ? '0 : cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/psf_timeout_ctr.sv
module psf_timeout_ctr #(
    parameter int TIMEOUT_TICKS = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [W-1:0] LAST = W'(TIMEOUT_TICKS - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = tick && !clr && (cnt_q == LAST);
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = expire ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/psf_mode_fsm.sv
module psf_mode_fsm
    import psf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst,
    input  logic       wake,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_fs_dis,
    input  logic       flag_clr,
    input  logic       expire,
    output ctl_state_t state_o,
    output logic       ctr_clr,
    output logic       ctr_en
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ext_rst) begin
            st_d.mode     = MODE_STANDBY;
            st_d.armed    = 1'b1;
            st_d.por_flag = 1'b1;
            st_d.fs_dis   = 1'b0;
        end else if (st_q.mode == MODE_SLEEP) begin
            if (wake) begin
                st_d.mode  = MODE_STANDBY;
                st_d.armed = 1'b1;
            end
        end else begin
            if (cfg_wr) begin
                st_d.fs_dis = cfg_fs_dis;
                case (cfg_mode)
                    REQ_NORMAL: begin
                        st_d.mode  = MODE_NORMAL;
                        st_d.armed = 1'b0;
                    end
                    REQ_STANDBY: st_d.mode = MODE_STANDBY;
                    default: ;
                endcase
            end
            if (flag_clr) begin
                st_d.por_flag = 1'b0;
                st_d.armed    = 1'b0;
            end
            if (expire && st_d.armed && !st_q.fs_dis) begin
                st_d.mode  = MODE_SLEEP;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= MODE_STANDBY;
            st_q.armed    <= 1'b1;
            st_q.por_flag <= 1'b1;
            st_q.fs_dis   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;
    assign ctr_clr = ext_rst || !st_q.armed;
    assign ctr_en  = st_q.armed && !st_q.fs_dis;
endmodule

// File: rtl/powerup_sleep_failsafe.sv
module powerup_sleep_failsafe
    import psf_pkg::*;
#(
    parameter int PRESCALE      = 40000,
    parameter int TIMEOUT_TICKS = 240000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst,
    input  logic       wake_btn,
    input  logic       wake_bus,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_fs_dis,
    input  logic       flag_clr,
    output logic [1:0] mode_o,
    output logic       spi_mute_o,
    output logic       por_flag_o,
    output logic       fs_dis_o
);
    ctl_state_t st;
    logic ctr_clr, ctr_en, tick, expire;

    psf_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .en   (ctr_en),
        .tick (tick)
    );

    psf_timeout_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .tick  (tick),
        .expire(expire)
    );

    psf_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_rst   (ext_rst),
        .wake      (wake_btn || wake_bus),
        .cfg_wr    (cfg_wr),
        .cfg_mode  (cfg_mode),
        .cfg_fs_dis(cfg_fs_dis),
        .flag_clr  (flag_clr),
        .expire    (expire),
        .state_o   (st),
        .ctr_clr   (ctr_clr),
        .ctr_en    (ctr_en)
    );

    assign mode_o     = st.mode;
    assign spi_mute_o = (st.mode == MODE_SLEEP);
    assign por_flag_o = st.por_flag;
    assign fs_dis_o   = st.fs_dis;
endmodule

// File: rtl/psf_checker.sv
module psf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_rst,
    input logic       wake_btn,
    input logic       wake_bus,
    input logic       cfg_wr,
    input logic [1:0] cfg_mode,
    input logic       flag_clr,
    input logic [1:0] mode_o,
    input logic       por_flag_o,
    input logic       fs_dis_o
);
    localparam logic [1:0] M_STBY  = 2'd0;
    localparam logic [1:0] M_NORM  = 2'd1;
    localparam logic [1:0] M_SLEEP = 2'd2;

    a_r2_sleep_only_from_armed_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP && $past(mode_o) != M_SLEEP)
            |-> ($past(mode_o) == M_STBY && $past(por_flag_o) && !$past(fs_dis_o)));

    a_r3_normal_request: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_mode == 2'b10 && mode_o != M_SLEEP && !ext_rst) |=> (mode_o == M_NORM));

    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && mode_o != M_SLEEP && !ext_rst) |=> !por_flag_o);

    a_r6_sleep_deaf: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP && !ext_rst && !wake_btn && !wake_bus)
            |=> (mode_o == M_SLEEP && $stable(por_flag_o) && $stable(fs_dis_o)));

    a_r7_wake_to_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SLEEP && (wake_btn || wake_bus) && !ext_rst) |=> (mode_o == M_STBY));

    a_r8_reset_request: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (mode_o == M_STBY && por_flag_o && !fs_dis_o));
endmodule

bind powerup_sleep_failsafe psf_checker u_psf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_rst   (ext_rst),
    .wake_btn  (wake_btn),
    .wake_bus  (wake_bus),
    .cfg_wr    (cfg_wr),
    .cfg_mode  (cfg_mode),
    .flag_clr  (flag_clr),
    .mode_o    (mode_o),
    .por_flag_o(por_flag_o),
    .fs_dis_o  (fs_dis_o)
);

// File: tb/powerup_sleep_failsafe_bench.sv
`timescale 1ns/1ps
module powerup_sleep_failsafe_bench;
    localparam int P = 4;
    localparam int T = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst = 0, wake_btn = 0, wake_bus = 0, cfg_wr = 0, cfg_fs_dis = 0, flag_clr = 0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] mode_o;
    logic spi_mute_o, por_flag_o, fs_dis_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    powerup_sleep_failsafe #(.PRESCALE(P), .TIMEOUT_TICKS(T)) u_powerup_sleep_failsafe (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .wake_btn(wake_btn),
        .wake_bus(wake_bus), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_fs_dis(cfg_fs_dis), .flag_clr(flag_clr), .mode_o(mode_o),
        .spi_mute_o(spi_mute_o), .por_flag_o(por_flag_o), .fs_dis_o(fs_dis_o)
    );

    // op: 0 idle, 1 config write, 2 flag clear, 3 button, 4 bus wake, 5 reset request
    typedef struct packed {
        logic [2:0] op;
        logic [1:0] mfield;
        logic       dis;
        logic [7:0] wt;
        logic [1:0] emode;
        logic       eflag;
        logic       edis;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'b00, 1'b0, 8'd18, 2'd0, 1'b1, 1'b0, 4'd2},  // R2 one edge before expiry
        '{3'd0, 2'b00, 1'b0, 8'd0,  2'd2, 1'b1, 1'b0, 4'd2},  // R2 expiry edge
        '{3'd1, 2'b10, 1'b1, 8'd2,  2'd2, 1'b1, 1'b0, 4'd6},  // R6 write ignored asleep
        '{3'd2, 2'b00, 1'b0, 8'd0,  2'd2, 1'b1, 1'b0, 4'd6},  // R6 clear ignored asleep
        '{3'd3, 2'b00, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd7},  // R7 button wake
        '{3'd0, 2'b00, 1'b0, 8'd18, 2'd0, 1'b1, 1'b0, 4'd7},  // R7 re-armed full window
        '{3'd0, 2'b00, 1'b0, 8'd0,  2'd2, 1'b1, 1'b0, 4'd7},  // R7 sleeps again
        '{3'd4, 2'b00, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd7},  // R7 bus wake
        '{3'd1, 2'b10, 1'b0, 8'd0,  2'd1, 1'b1, 1'b0, 4'd3},  // R3 go normal
        '{3'd0, 2'b00, 1'b0, 8'd40, 2'd1, 1'b1, 1'b0, 4'd3},  // R3 countdown cancelled
        '{3'd1, 2'b01, 1'b0, 8'd40, 2'd0, 1'b1, 1'b0, 4'd3},  // R3 standby, not re-armed
        '{3'd3, 2'b00, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd7},  // R7 wake while awake
        '{3'd5, 2'b00, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd8},  // R8 reset request
        '{3'd1, 2'b00, 1'b1, 8'd0,  2'd0, 1'b1, 1'b1, 4'd10}, // R10 keep mode, set disable
        '{3'd0, 2'b00, 1'b0, 8'd60, 2'd0, 1'b1, 1'b1, 4'd5},  // R5 frozen
        '{3'd1, 2'b11, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd10}, // R10 keep mode, clear disable
        '{3'd0, 2'b00, 1'b0, 8'd17, 2'd0, 1'b1, 1'b0, 4'd5},  // R5 resumed, one tick short
        '{3'd0, 2'b00, 1'b0, 8'd0,  2'd2, 1'b1, 1'b0, 4'd5},  // R5 remaining window done
        '{3'd5, 2'b00, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd8},  // R8 from sleep
        '{3'd2, 2'b00, 1'b0, 8'd0,  2'd0, 1'b0, 1'b0, 4'd4},  // R4 flag cleared
        '{3'd0, 2'b00, 1'b0, 8'd60, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 countdown cancelled
        '{3'd5, 2'b00, 1'b0, 8'd0,  2'd0, 1'b1, 1'b0, 4'd8},  // R8 flag set again
        '{3'd0, 2'b00, 1'b0, 8'd18, 2'd0, 1'b1, 1'b0, 4'd9},  // R9 approach expiry
        '{3'd1, 2'b10, 1'b0, 8'd0,  2'd1, 1'b1, 1'b0, 4'd9},  // R9 write on expiry edge
        '{3'd0, 2'b00, 1'b0, 8'd40, 2'd1, 1'b1, 1'b0, 4'd9}   // R9 stays normal
    };

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic chk_all(input string tag, input int em, input int ef, input int ed);
        chk(tag, "mode", int'(mode_o), em);
        chk(tag, "flag", int'(por_flag_o), ef);
        chk(tag, "disable", int'(fs_dis_o), ed);
        chk(tag, "mute", int'(spi_mute_o), (em == 2) ? 1 : 0);
    endtask

    task automatic clear_inputs();
        ext_rst = 0; wake_btn = 0; wake_bus = 0; cfg_wr = 0; flag_clr = 0;
        cfg_mode = 2'b00; cfg_fs_dis = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_inputs();
        idle(3);
        chk_all("R1 during reset", 0, 1, 0);
        rst_n = 1'b1;
        chk_all("R1 after release", 0, 1, 0);

        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                3'd1: begin cfg_wr = 1; cfg_mode = VECS[i].mfield; cfg_fs_dis = VECS[i].dis; end
                3'd2: flag_clr = 1;
                3'd3: wake_btn = 1;
                3'd4: wake_bus = 1;
                3'd5: ext_rst = 1;
                default: ;
            endcase
            @(negedge clk);
            clear_inputs();
            idle(int'(VECS[i].wt));
            chk_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                    int'(VECS[i].emode), int'(VECS[i].eflag), int'(VECS[i].edis));
        end

        // R8: reset request overrides a concurrent write and wake, then full window
        cfg_wr = 1; cfg_mode = 2'b10; cfg_fs_dis = 1; wake_btn = 1; ext_rst = 1;
        @(negedge clk); clear_inputs();
        chk_all("R8 priority", 0, 1, 0);
        idle(P*T - 1);
        chk_all("R8 window not yet over", 0, 1, 0);
        idle(1);
        chk_all("R8 full window", 2, 1, 0);

        // R7 and R6: wake with a concurrent write, the write is discarded
        wake_bus = 1; cfg_wr = 1; cfg_mode = 2'b10; cfg_fs_dis = 1;
        @(negedge clk); clear_inputs();
        chk_all("R7 wake, R6 write dropped", 0, 1, 0);

        // R1: power-on reset in the middle of operation clears the disable bit
        cfg_wr = 1; cfg_mode = 2'b10; cfg_fs_dis = 1;
        @(negedge clk); clear_inputs();
        chk_all("R10 disable set in normal", 1, 1, 1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk_all("R1 power cycle", 0, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule